// File: doc/BRIEF.md
# Touch Key State Manager

This block turns per-pad "touched" flags from a capacitive sensing front end into the key status word that the rest of the chip reads, and into eight direct key outputs. Configuration straps choose how many pads are in use (8 or 16), whether one key or several keys may be reported at once, whether a held key is cut off after a maximum on-time, and the electrical form of the direct outputs: push-pull, open-drain or open-collector. Push-pull and the open forms appear on the pins as a drive-enable and a drive level.

After reset the block ignores all pads for a settling period and holds every output at its inactive value. After that it registers the arbitrated pad state each clock. It counts how long each key stays on, and it counts how long all keys have been idle. When either count runs out it sends a one-cycle request to recalibrate the front end. All time intervals are counted on a one-millisecond `tick` input, and each limit is a parameter.

Top module: `touch_key_mgr`

## Requirements
- R1: From reset release (after a two-clock reset synchronizer) until SETTLE_TICKS ticks have been counted, `key_status` is zero, `recal_req` is low, and the direct outputs and `data_valid` are at their inactive encodings.
- R2: With `cfg_wide`=0 only pads 0..7 are considered, and `key_status[15:8]` stays zero whatever pads 8..15 do.
- R3: With `cfg_wide`=1 all 16 pads are reported, and `direct_oe` and `direct_lvl` are all zero.
- R4: With `cfg_multi`=0, when several eligible pads are on, only the lowest-numbered one appears in `key_status`.
- R5: With `cfg_multi`=1 every eligible pad that is on appears in `key_status`.
- R6: `key_status` follows the pads with one clock of latency: it changes at the first rising edge after `pad_raw` changes.
- R7: With `cfg_hold_limit`=1, a pad held for KEYON_TICKS ticks is forced off and `recal_req` pulses for one cycle. The pad stays off until its raw flag has been seen low.
- R8: With `cfg_hold_limit`=0 a held pad is never forced off.
- R9: When no eligible pad is on for IDLE_TICKS consecutive ticks, `recal_req` pulses for one cycle and the idle count starts again.
- R10: Push-pull style (`cfg_open`=0, 8-pad mode): every bit of `direct_oe` is 1, and `direct_lvl[i]` = `key_status[i]` XOR `cfg_invert`.
- R11: Open style (`cfg_open`=1, 8-pad mode): `direct_oe[i]` = `key_status[i]`, and every bit of `direct_lvl` equals `cfg_invert` (0 sinks low for open-drain, 1 drives high for open-collector).
- R12: `data_valid` = (any bit of `key_status` set) XOR `cfg_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond |
| pad_raw | input | 16 | Raw touched flag per pad |
| cfg_wide | input | 1 | 1 = 16-pad mode, 0 = 8-pad mode |
| cfg_multi | input | 1 | 1 = multi-key, 0 = single-key |
| cfg_hold_limit | input | 1 | 1 = enable the maximum key-on time |
| cfg_invert | input | 1 | Polarity / open-style selector |
| cfg_open | input | 1 | 1 = open output style, 0 = push-pull |
| key_status | output | 16 | Registered key state |
| direct_oe | output | 8 | Per-pin drive enable |
| direct_lvl | output | 8 | Per-pin drive level |
| data_valid | output | 1 | Any-key indicator with selected polarity |
| recal_req | output | 1 | One-cycle recalibration request |

## Verification
The hardest case to reach is the key-on limit. The pad must stay on across the whole limit while the other pads stay quiet, and the bench must then see that the key remains off, and does not come back, until the pad is released and touched again. The bench uses short parameter values for the limits and holds a single pad for longer than the limit. It checks the forced-off state, then releases and re-presses the pad to show that it is reported again. A behavioural model compared on every clock also confirms the exact cycle of each recalibration pulse, including the idle pulse that follows once the locked key no longer counts as active.

// File: rtl/tkm_pkg.sv
package tkm_pkg;
  typedef enum logic {
    STYLE_PUSHPULL = 1'b0,
    STYLE_OPEN     = 1'b1
  } drive_style_e;
endpackage

// File: rtl/tkm_tick_timer.sv
module tkm_tick_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign hit = step & ~clr & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (step)  cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R9
endmodule

// File: rtl/tkm_hold_limit.sv
module tkm_hold_limit #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_on,
  input  logic tick,
  input  logic enable,
  output logic locked,
  output logic expire
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         lock_q, lock_d;
  logic         at_end;

  assign at_end = (cnt_q == LAST);
  assign expire = pad_on & tick & ~lock_q & at_end & enable;
  assign locked = lock_q;

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (!pad_on) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (tick && !lock_q) begin
      if (!at_end)      cnt_d  = cnt_q + 1'b1;
      else if (enable)  lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && pad_on) |=> lock_q); // R7
endmodule

// File: rtl/tkm_arbiter.sv
module tkm_arbiter #(
  parameter int N = 16
) (
  input  logic [N-1:0] eligible,
  input  logic         multi,
  output logic [N-1:0] pick
);
  logic [N-1:0] lowest;

  always_comb begin
    lowest = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        lowest    = '0;
        lowest[i] = 1'b1;
      end
    end
    pick = multi ? eligible : lowest;
  end
endmodule

// File: rtl/tkm_out_enc.sv
module tkm_out_enc
  import tkm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]  keys,
  input  logic          wide,
  input  logic          invert,
  input  drive_style_e  style,
  output logic [N-1:0]  oe,
  output logic [N-1:0]  lvl
);
  always_comb begin
    if (wide) begin
      oe  = '0;
      lvl = '0;
    end else if (style == STYLE_OPEN) begin
      oe  = keys;
      lvl = {N{invert}};
    end else begin
      oe  = '1;
      lvl = keys ^ {N{invert}};
    end
  end
endmodule

// File: rtl/touch_key_mgr.sv
module touch_key_mgr
  import tkm_pkg::*;
#(
  parameter int NPAD         = 16,
  parameter int DIRECT       = 8,
  parameter int SETTLE_TICKS = 500,
  parameter int KEYON_TICKS  = 80000,
  parameter int IDLE_TICKS   = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NPAD-1:0]   pad_raw,
  input  logic              cfg_wide,
  input  logic              cfg_multi,
  input  logic              cfg_hold_limit,
  input  logic              cfg_invert,
  input  logic              cfg_open,
  output logic [NPAD-1:0]   key_status,
  output logic [DIRECT-1:0] direct_oe,
  output logic [DIRECT-1:0] direct_lvl,
  output logic              data_valid,
  output logic              recal_req
);
  localparam logic [NPAD-1:0] NARROW_MASK = {{(NPAD-DIRECT){1'b0}}, {DIRECT{1'b1}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // power-on settling blackout
  logic settled_q, settled_d, settle_hit;
  tkm_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_s), .clr(1'b0),
    .step(tick & ~settled_q), .hit(settle_hit)
  );
  assign settled_d = settled_q | settle_hit;

  // eligible pads
  logic [NPAD-1:0] lane_mask, pad_on, lock_vec, expire_vec, eligible, pick;
  assign lane_mask = cfg_wide ? '1 : NARROW_MASK;
  assign pad_on    = settled_q ? (pad_raw & lane_mask) : '0;

  for (genvar g = 0; g < NPAD; g++) begin : g_hold
    tkm_hold_limit #(.LIMIT(KEYON_TICKS)) u_hold (
      .clk(clk), .rst_n(rst_s), .pad_on(pad_on[g]), .tick(tick),
      .enable(cfg_hold_limit), .locked(lock_vec[g]), .expire(expire_vec[g])
    );
  end

  assign eligible = pad_on & ~lock_vec;

  tkm_arbiter #(.N(NPAD)) u_arb (
    .eligible(eligible), .multi(cfg_multi), .pick(pick)
  );

  // idle recalibration timer
  logic idle_hit;
  tkm_tick_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_s), .clr(~settled_q | (|eligible)),
    .step(tick), .hit(idle_hit)
  );

  // next state and registers
  logic [NPAD-1:0] key_q, key_d;
  logic            recal_q, recal_d;
  always_comb begin
    key_d   = pick;
    recal_d = idle_hit | (|expire_vec);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      key_q     <= '0;
      recal_q   <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      key_q     <= key_d;
      recal_q   <= recal_d;
      settled_q <= settled_d;
    end
  end

  tkm_out_enc #(.N(DIRECT)) u_enc (
    .keys(key_q[DIRECT-1:0]), .wide(cfg_wide), .invert(cfg_invert),
    .style(drive_style_e'(cfg_open)), .oe(direct_oe), .lvl(direct_lvl)
  );

  assign key_status = key_q;
  assign recal_req  = recal_q;
  assign data_valid = (|key_q) ^ cfg_invert;

  AST_BLACKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !settled_q |-> (key_q == '0 && !recal_q)); // R1
  AST_SETTLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_s)
    settled_q |=> settled_q); // R1
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(cfg_wide) |-> key_q[NPAD-1:DIRECT] == '0); // R2
  AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(cfg_multi) |-> $onehot0(key_q)); // R4
endmodule

// File: tb/sim_touch_key_mgr.sv
module sim_touch_key_mgr;
  localparam int S = 5;
  localparam int K = 20;
  localparam int I = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [15:0] pad_raw;
  logic        cfg_wide, cfg_multi, cfg_hold_limit, cfg_invert, cfg_open;
  logic [15:0] key_status;
  logic [7:0]  direct_oe, direct_lvl;
  logic        data_valid, recal_req;

  touch_key_mgr #(.NPAD(16), .DIRECT(8), .SETTLE_TICKS(S),
                  .KEYON_TICKS(K), .IDLE_TICKS(I)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pad_raw(pad_raw),
    .cfg_wide(cfg_wide), .cfg_multi(cfg_multi), .cfg_hold_limit(cfg_hold_limit),
    .cfg_invert(cfg_invert), .cfg_open(cfg_open), .key_status(key_status),
    .direct_oe(direct_oe), .direct_lvl(direct_lvl), .data_valid(data_valid),
    .recal_req(recal_req)
  );

  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int recal_seen = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // millisecond tick stand-in: one pulse every four clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick <= (tdiv == 3);
  end

  // behavioural reference model
  logic [15:0] m_ks = '0, m_lock = '0;
  int          m_cnt[16];
  int          m_scnt = 0, m_icnt = 0;
  bit          m_settled = 0, m_recal = 0;
  logic [1:0]  m_pipe = 2'b00;

  always @(posedge clk) begin
    logic [15:0] mask, on, eff, sel, nlock;
    bit expire, idlehit;
    cycles++;
    if (cycles > 50000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      finish_run();
    end
    if (!rst_n) begin
      m_ks = '0; m_lock = '0; m_scnt = 0; m_icnt = 0;
      m_settled = 0; m_recal = 0; m_pipe = 2'b00;
      for (int i = 0; i < 16; i++) m_cnt[i] = 0;
    end else begin
      if (m_pipe[1]) begin
        mask = cfg_wide ? 16'hFFFF : 16'h00FF;
        on   = m_settled ? (pad_raw & mask) : 16'h0;
        eff  = on & ~m_lock;
        sel  = eff;
        if (!cfg_multi) begin
          sel = 16'h0;
          for (int i = 0; i < 16; i++) if (eff[i]) begin sel = 16'(1) << i; break; end
        end
        expire = 0;
        nlock  = m_lock;
        for (int i = 0; i < 16; i++) begin
          if (!on[i]) begin
            m_cnt[i] = 0; nlock[i] = 1'b0;
          end else if (tick && !m_lock[i]) begin
            if (m_cnt[i] == K - 1) begin
              if (cfg_hold_limit) begin nlock[i] = 1'b1; expire = 1; end
            end else m_cnt[i]++;
          end
        end
        idlehit = 0;
        if (!m_settled || eff != 0) m_icnt = 0;
        else if (tick) begin
          if (m_icnt == I - 1) begin m_icnt = 0; idlehit = 1; end
          else m_icnt++;
        end
        if (!m_settled && tick) begin
          if (m_scnt == S - 1) begin m_settled = 1; m_scnt = 0; end
          else m_scnt++;
        end
        m_ks    = sel;
        m_recal = idlehit | expire;
        m_lock  = nlock;
      end
      m_pipe = {m_pipe[0], 1'b1};
    end
    #1;
    if (rst_n && !done) begin
      logic [7:0] e_oe, e_lvl;
      logic e_dv;
      e_oe  = cfg_wide ? 8'h00 : (cfg_open ? m_ks[7:0] : 8'hFF);
      e_lvl = cfg_wide ? 8'h00 : (cfg_open ? {8{cfg_invert}} : (m_ks[7:0] ^ {8{cfg_invert}}));
      e_dv  = (|m_ks) ^ cfg_invert;
      if (recal_req) recal_seen++;
      chk(key_status == m_ks, "R2 R3 R4 R5 R6 R7 R8 key_status", key_status, m_ks);
      chk(recal_req == m_recal, "R7 R9 recal_req", recal_req, m_recal);
      chk(direct_oe == e_oe, "R10 R11 direct_oe", direct_oe, e_oe);
      chk(direct_lvl == e_lvl, "R10 R11 direct_lvl", direct_lvl, e_lvl);
      chk(data_valid == e_dv, "R12 data_valid", data_valid, e_dv);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int r0;
    rst_n = 1'b0;
    pad_raw = 16'h0003;
    cfg_wide = 0; cfg_multi = 0; cfg_hold_limit = 0; cfg_invert = 0; cfg_open = 0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(8);
    chk(key_status == 16'h0, "R1 blackout keys", key_status, 0);
    chk(data_valid == 1'b0, "R1 blackout data_valid", data_valid, 0);
    chk(direct_lvl == 8'h00 && direct_oe == 8'hFF, "R1 blackout direct", {direct_oe, direct_lvl}, 16'hFF00);
    wait_clk(30);
    chk(key_status == 16'h0001, "R4 single after settle", key_status, 16'h0001);

    pad_raw = 16'h0F06;
    wait_clk(3);
    chk(key_status == 16'h0002, "R2 R4 narrow single", key_status, 16'h0002);
    chk(data_valid == 1'b1, "R12 active high", data_valid, 1);
    chk(direct_oe == 8'hFF && direct_lvl == 8'h02, "R10 push-pull", {direct_oe, direct_lvl}, 16'hFF02);
    cfg_multi = 1;
    wait_clk(3);
    chk(key_status == 16'h0006, "R5 R2 narrow multi", key_status, 16'h0006);
    cfg_wide = 1;
    wait_clk(3);
    chk(key_status == 16'h0F06, "R3 wide multi", key_status, 16'h0F06);
    chk(direct_oe == 8'h00, "R3 direct off", direct_oe, 0);

    cfg_wide = 0;
    wait_clk(2);
    pad_raw = 16'h0010;
    #1 chk(key_status == 16'h0006, "R6 before edge", key_status, 16'h0006);
    wait_clk(1);
    chk(key_status == 16'h0010, "R6 one clock later", key_status, 16'h0010);

    pad_raw = 16'h0005;
    cfg_open = 1;
    wait_clk(3);
    chk(direct_oe == 8'h05 && direct_lvl == 8'h00, "R11 open drain", {direct_oe, direct_lvl}, 16'h0500);
    cfg_invert = 1;
    wait_clk(1);
    chk(direct_lvl == 8'hFF, "R11 open collector", direct_lvl, 8'hFF);
    chk(data_valid == 1'b0, "R12 active low", data_valid, 0);
    cfg_open = 0;
    wait_clk(1);
    chk(direct_lvl == 8'hFA, "R10 inverted push-pull", direct_lvl, 8'hFA);
    cfg_invert = 0;
    cfg_multi = 0;

    pad_raw = 16'h0001;
    cfg_hold_limit = 1;
    r0 = recal_seen;
    wait_clk(100);
    chk(key_status == 16'h0000, "R7 forced off", key_status, 0);
    chk(recal_seen > r0, "R7 recal on expiry", recal_seen - r0, 1);
    pad_raw = 16'h0000;
    wait_clk(3);
    pad_raw = 16'h0001;
    wait_clk(3);
    chk(key_status == 16'h0001, "R7 back after release", key_status, 1);

    cfg_hold_limit = 0;
    wait_clk(120);
    chk(key_status == 16'h0001, "R8 no limit", key_status, 1);

    pad_raw = 16'h0000;
    r0 = recal_seen;
    wait_clk(60);
    chk(recal_seen > r0, "R9 idle recal", recal_seen - r0, 1);

    done = 1;
    finish_run();
  end
endmodule